// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is addressed to this station. The receive path presents the 48-bit destination address together with a one-cycle strobe. One clock later the block returns an accept flag and a reason code. The lookup first compares the address against a table of sixteen station addresses. An entry takes part in that comparison only while its valid flag is set.

If no valid entry matches, the block falls back to a hashed multicast table of 4096 bits. The hash index is twelve bits cut from destination bytes 5 and 4, at a shift that software selects. A saturating counter records every frame that the hash table accepted.

Software programs the station table, the hash table and the shift mode through a simple write port. Writes take effect at the clock edge that samples them. A lookup strobed in the same cycle as a write still sees the old contents.

Top module: `rx_dest_filter`

## Requirements
- R1: A strobed address equal to the 48-bit address of any valid station entry (0 to 15, including the last) is accepted with reason code 2'b01.
- R2: A station entry whose valid flag (bit 31 of its high word) is clear never produces a match. Clearing the flag of a programmed entry withdraws its match.
- R3: An exact match compares all six bytes. Byte 0 sits in dstAddr[7:0] and in low word bits [7:0], and byte 3 in low word bits [31:24]. Byte 4 sits in high word bits [7:0] and byte 5 in high word bits [15:8]. A difference in any single byte defeats the match.
- R4: The hash value is {byte5, byte4} shifted right by 4, 3, 2 or 0 for mode values 0, 1, 2 and 3. Only the low 12 bits of the shifted value are kept.
- R5: Hash bits [11:5] pick one of 128 table words and bits [4:0] pick the bit within that word. A set bit accepts the frame with reason code 2'b10. Word 0 bit 0 and word 127 bit 31 are both reachable.
- R6: The hash table is consulted only when no valid station entry matched. An address that hits both is reported with reason 2'b01.
- R7: The hit counter increments by one for each frame accepted through the hash table, and only for those frames. It holds at all ones once it gets there.
- R8: The result is registered. resValid is high exactly in the cycle after a strobe. When resValid is low, resAccept is low and resReason is 2'b00.
- R9: Reset clears every station valid flag, the whole hash table, the shift mode (to 0), the counter and the result outputs.
- R10: Write map on cfgAddr[8:7]. Value 00 is a station word: cfgAddr[4:1] gives the entry and cfgAddr[0] selects the high word. Value 01 is a hash word, indexed by cfgAddr[6:0]. Value 10 is the mode, taken from cfgData[1:0]. A write with value 11 changes nothing.
- R11: Reason code 2'b00 means rejected. resAccept is high exactly when resReason is not 2'b00, and code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 9 | Configuration word address |
| cfgData | input | 32 | Configuration write data |
| dstValid | input | 1 | Destination address strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| resValid | output | 1 | Result valid, one cycle after the strobe |
| resAccept | output | 1 | Frame accepted |
| resReason | output | 2 | 00 none, 01 station match, 10 hash match |
| mcHitCount | output | CNT_W | Saturating count of hash-table accepts |

## Verification
The address patterns are chosen so that each one isolates a single cause.

- Exact copies of the first and last station entries, and of an entry programmed with its valid flag clear, separate a true table match from a skipped entry.
- Addresses that differ from a station entry in byte 0 or in byte 5 alone show that all six bytes are compared. The byte-0 variant also shares its hash bit, so it falls through to the hash path.
- One multicast address is tried under all four shift modes with only two of its indices set. This tells the shift amounts apart.
- Addresses hashing to index 0 and index 4095 confirm the word and bit split.
- A station address whose hash bit is also set shows the precedence rule and that the counter does not move.
- A long back-to-back burst of hash hits drives the narrow counter into saturation.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_EXACT = 2'b01,
    RSN_HASH  = 2'b10
  } reason_e;

  // strobes from control to datapath for one configuration write
  typedef struct packed {
    logic       staLoWe;
    logic       staHiWe;
    logic       hashWe;
    logic       modeWe;
    logic [7:0] idx;
  } cfgStrobe_t;

endpackage

// File: rtl/rxflt_datapath.sv
module rxflt_datapath
  import rxflt_pkg::*;
#(
  parameter int NUM_ENT    = 16,
  parameter int HASH_WORDS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobes,
  input  logic [31:0] cfgData,
  input  logic [47:0] dstAddr,
  output logic        exactHit,
  output logic        hashHit
);
  localparam int ENT_IW  = $clog2(NUM_ENT);
  localparam int HASH_IW = $clog2(HASH_WORDS);
  localparam int HASH_W  = HASH_IW + 5;

  logic [31:0] staLo   [NUM_ENT];
  logic [15:0] staHi   [NUM_ENT];
  logic [NUM_ENT-1:0] staValid;
  logic [31:0] hashMem [HASH_WORDS];
  logic [1:0]  hashMode;

  logic [ENT_IW-1:0]  entSel;
  logic [HASH_IW-1:0] wordSel;
  assign entSel  = strobes.idx[ENT_IW-1:0];
  assign wordSel = strobes.idx[HASH_IW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      staValid <= '0;
      hashMode <= 2'd0;
      for (int i = 0; i < NUM_ENT; i++) begin
        staLo[i] <= '0;
        staHi[i] <= '0;
      end
      for (int w = 0; w < HASH_WORDS; w++) hashMem[w] <= '0;
    end else begin
      if (strobes.staLoWe) staLo[entSel] <= cfgData;
      if (strobes.staHiWe) begin
        staHi[entSel]    <= cfgData[15:0];
        staValid[entSel] <= cfgData[31];
      end
      if (strobes.hashWe) hashMem[wordSel] <= cfgData;
      if (strobes.modeWe) hashMode <= cfgData[1:0];
    end
  end

  // exact compare, one comparator per entry
  logic [NUM_ENT-1:0] entHit;
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign entHit[e] = staValid[e] && ({staHi[e], staLo[e]} == dstAddr);
  end
  assign exactHit = |entHit;

  // hash index from the last two address bytes
  logic [15:0] tailBytes;
  logic [15:0] shifted;
  logic [HASH_W-1:0] hashIdx;
  assign tailBytes = dstAddr[47:32];

  always_comb begin
    case (hashMode)
      2'd0:    shifted = tailBytes >> 4;
      2'd1:    shifted = tailBytes >> 3;
      2'd2:    shifted = tailBytes >> 2;
      default: shifted = tailBytes;
    endcase
  end

  assign hashIdx = shifted[HASH_W-1:0];
  assign hashHit = hashMem[hashIdx[HASH_W-1:5]][hashIdx[4:0]];

endmodule

// File: rtl/rxflt_ctrl.sv
module rxflt_ctrl
  import rxflt_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int ENT_IW  = 4,
  parameter int HASH_IW = 7,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              dstValid,
  input  logic              exactHit,
  input  logic              hashHit,
  output cfgStrobe_t        strobes,
  output logic              resValid,
  output logic              resAccept,
  output logic [1:0]        resReason,
  output logic [CNT_W-1:0]  mcHitCount
);
  localparam logic [1:0] REG_STA  = 2'b00;
  localparam logic [1:0] REG_HASH = 2'b01;
  localparam logic [1:0] REG_MODE = 2'b10;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] region;
  assign region = cfgAddr[ADDR_W-1 -: 2];

  always_comb begin
    strobes = '0;
    if (cfgWe) begin
      case (region)
        REG_STA: begin
          strobes.staLoWe = !cfgAddr[0];
          strobes.staHiWe = cfgAddr[0];
          strobes.idx     = 8'(cfgAddr[ENT_IW:1]);
        end
        REG_HASH: begin
          strobes.hashWe = 1'b1;
          strobes.idx    = 8'(cfgAddr[HASH_IW-1:0]);
        end
        REG_MODE: strobes.modeWe = 1'b1;
        default:  ;
      endcase
    end
  end

  reason_e nextReason;
  always_comb begin
    nextReason = RSN_NONE;
    if (dstValid) begin
      if (exactHit)     nextReason = RSN_EXACT;
      else if (hashHit) nextReason = RSN_HASH;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resAccept  <= 1'b0;
      resReason  <= 2'b00;
      mcHitCount <= '0;
    end else begin
      resValid  <= dstValid;
      resAccept <= nextReason != RSN_NONE;
      resReason <= nextReason;
      if (nextReason == RSN_HASH && mcHitCount != CNT_MAX)
        mcHitCount <= mcHitCount + 1'b1;
    end
  end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxflt_pkg::*;
#(
  parameter int NUM_ENT    = 16,
  parameter int HASH_WORDS = 128,
  parameter int ADDR_W     = 9,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              dstValid,
  input  logic [47:0]       dstAddr,
  output logic              resValid,
  output logic              resAccept,
  output logic [1:0]        resReason,
  output logic [CNT_W-1:0]  mcHitCount
);
  localparam int ENT_IW  = $clog2(NUM_ENT);
  localparam int HASH_IW = $clog2(HASH_WORDS);

  cfgStrobe_t strobes;
  logic exactHit;
  logic hashHit;

  rxflt_ctrl #(
    .ADDR_W(ADDR_W), .ENT_IW(ENT_IW), .HASH_IW(HASH_IW), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .dstValid(dstValid), .exactHit(exactHit), .hashHit(hashHit),
    .strobes(strobes), .resValid(resValid), .resAccept(resAccept),
    .resReason(resReason), .mcHitCount(mcHitCount)
  );

  rxflt_datapath #(
    .NUM_ENT(NUM_ENT), .HASH_WORDS(HASH_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgData(cfgData),
    .dstAddr(dstAddr), .exactHit(exactHit), .hashHit(hashHit)
  );

endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             dstValid,
  input logic             resValid,
  input logic             resAccept,
  input logic [1:0]       resReason,
  input logic [CNT_W-1:0] mcHitCount
);
  // R8
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dstValid |=> resValid);
  // R8
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dstValid |=> (!resValid && !resAccept && resReason == 2'b00));
  // R11
  accept_reason_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resAccept == (resReason != 2'b00)) && (resReason != 2'b11));
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (mcHitCount == $past(mcHitCount) || mcHitCount == $past(mcHitCount) + 1'b1));
  // R7
  cnt_only_hash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resReason != 2'b10) |-> (mcHitCount == $past(mcHitCount)));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (mcHitCount == '0 && !resValid));
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .dstValid(dstValid), .resValid(resValid),
  .resAccept(resAccept), .resReason(resReason), .mcHitCount(mcHitCount)
);

// File: tb/sim_rx_dest_filter.sv
module sim_rx_dest_filter;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [8:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic dstValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic resValid, resAccept;
  logic [1:0] resReason;
  logic [CW-1:0] mcHitCount;

  int nChecks = 0;
  int nFails = 0;
  int hashCount = 0;

  always #2.5 clk = ~clk;

  rx_dest_filter #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .dstValid(dstValid), .dstAddr(dstAddr), .resValid(resValid),
    .resAccept(resAccept), .resReason(resReason), .mcHitCount(mcHitCount)
  );

  logic [31:0] shadowHash [128];

  localparam logic [47:0] ENT0  = 48'h5544_3322_1102;
  localparam logic [47:0] ENT15 = 48'h0FEE_DDCC_BBAA;
  localparam logic [47:0] DEAD  = 48'h0100_0000_0006;
  localparam logic [47:0] MCA   = 48'h1234_0000_0000;
  localparam logic [47:0] TOP   = 48'hFFFF_0000_0000;
  localparam logic [47:0] LOW   = 48'h000F_0000_0000;

  // {mode, address, expected reason}
  localparam int NV = 11;
  localparam logic [51:0] VEC [NV] = '{
    {2'd0, ENT0,  2'b01},               // R1 first entry, R6 hash bit also set
    {2'd0, ENT15, 2'b01},               // R1 last entry
    {2'd0, DEAD,  2'b00},               // R2 entry with valid clear
    {2'd0, MCA,   2'b10},               // R4 shift 4
    {2'd1, MCA,   2'b00},               // R4 shift 3
    {2'd2, MCA,   2'b10},               // R4 shift 2
    {2'd3, MCA,   2'b00},               // R4 shift 0
    {2'd0, 48'h5644_3322_1102, 2'b00},  // R3 byte 5 differs
    {2'd0, 48'h5544_3322_1103, 2'b10},  // R3 byte 0 differs, R6 falls to hash
    {2'd3, TOP,   2'b10},               // R5 word 127 bit 31
    {2'd0, LOW,   2'b10}                // R5 word 0 bit 0
  };

  function automatic logic [11:0] hashOf(input logic [47:0] a, input logic [1:0] m);
    logic [15:0] t;
    t = {a[47:40], a[39:32]};
    case (m)
      2'd0: t = t >> 4;
      2'd1: t = t >> 3;
      2'd2: t = t >> 2;
      default: ;
    endcase
    return t[11:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setEntry(input int idx, input logic [47:0] a, input logic v);
    cfgWrite({2'b00, 2'b00, idx[3:0], 1'b0}, a[31:0]);
    cfgWrite({2'b00, 2'b00, idx[3:0], 1'b1}, {v, 15'd0, a[47:32]});
  endtask

  task automatic setHash(input logic [47:0] a, input logic [1:0] m);
    logic [11:0] h;
    h = hashOf(a, m);
    shadowHash[h[11:5]][h[4:0]] = 1'b1;
    cfgWrite({2'b01, h[11:5]}, shadowHash[h[11:5]]);
  endtask

  task automatic lookup(input logic [47:0] a, input logic [1:0] expR, input string req);
    @(negedge clk);
    dstValid = 1'b1; dstAddr = a;
    @(negedge clk);
    dstValid = 1'b0;
    if (expR == 2'b10 && hashCount < (1 << CW) - 1) hashCount++;
    check({req, " valid"}, 32'(resValid), 32'd1);
    check({req, " reason"}, 32'(resReason), 32'(expR));
    check({req, " accept"}, 32'(resAccept), 32'(expR != 2'b00));
    check({req, " count"}, 32'(mcHitCount), 32'(hashCount));
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 128; w++) shadowHash[w] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", 32'(resValid), 32'd0);
    check("R9 count", 32'(mcHitCount), 32'd0);
    rstN = 1'b1;
    lookup(ENT0, 2'b00, "R9 empty tables");

    setEntry(0, ENT0, 1'b1);
    setEntry(15, ENT15, 1'b1);
    setEntry(3, DEAD, 1'b0);
    setHash(MCA, 2'd0);
    setHash(MCA, 2'd2);
    setHash(ENT0, 2'd0);
    setHash(TOP, 2'd3);
    setHash(LOW, 2'd0);

    for (int v = 0; v < NV; v++) begin
      cfgWrite(9'h100, {30'd0, VEC[v][51:50]});   // R10 mode write
      lookup(VEC[v][49:2], VEC[v][1:0], $sformatf("vector %0d", v));
    end

    // R8 no strobe, no result
    @(negedge clk);
    check("R8 idle valid", 32'(resValid), 32'd0);

    // R2 withdraw entry 0, its hash bit still catches it
    cfgWrite(9'h100, 32'd0);
    setEntry(0, ENT0, 1'b0);
    lookup(ENT0, 2'b10, "R2 withdrawn entry");

    // R7 back-to-back burst into saturation
    @(negedge clk);
    dstValid = 1'b1; dstAddr = MCA;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R8 burst valid", 32'(resValid), 32'd1);
    end
    dstValid = 1'b0;
    @(negedge clk);
    check("R7 saturated", 32'(mcHitCount), 32'((1 << CW) - 1));

    // R10 region 11 ignored: mode stays 0 so MCA still hits
    cfgWrite(9'h180, 32'd3);
    hashCount = (1 << CW) - 1;
    lookup(MCA, 2'b10, "R10 ignored region");

    // R9 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    hashCount = 0;
    check("R9 count cleared", 32'(mcHitCount), 32'd0);
    lookup(ENT15, 2'b00, "R9 valid flags cleared");
    lookup(MCA, 2'b00, "R9 hash cleared");
    for (int w = 0; w < 128; w++) shadowHash[w] = '0;
    setHash(MCA, 2'd0);
    lookup(MCA, 2'b10, "R9 mode back to 0");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule